// File: doc/BRIEF.md
# Strip-Mining Vector Length Sequencer

This block splits an element count, known only at run time, into pieces that each fit a vector register of at most 64 elements. Software or a front end gives it the count and one base byte address per stream (a source and a destination) together with a one-cycle start pulse. The sequencer then offers one segment at a time to a downstream vector executor. Each segment carries the vector length to load, the byte address of the segment in the source stream and the byte address in the destination stream.

The odd-sized piece comes first. When the count is not a multiple of 64, the first segment holds the leftover elements. Every segment after it is a full 64. Addresses move forward by eight bytes per element after each segment. A segment is handed over with a valid/ready handshake, and the sequencer moves on only when the executor takes it. When no elements remain, a completion strobe marks the end of the job and the block goes idle.

Top module: `vl_strip_seq`

## Requirements
- R1: While `segValid` is high, `segLen` lies between 1 and 64 inclusive. `segLen` is a plain binary count, so a full segment reads 64.
- R2: The first segment of a job has length N mod 64 when that is nonzero, and 64 when it is zero. Every later segment has length 64, so N = 200 yields 8, 64, 64, 64. The first segment is presented in the cycle after the start pulse is taken.
- R3: The first segment's `segSrc` and `segDst` equal the bases given at start. After each accepted segment, both addresses grow by `segLen` × 8.
- R4: Once no elements remain, `done` is high for exactly one cycle with `segValid` low. In that cycle `segSrc` = source base + 8·N and `segDst` = destination base + 8·N. `busy` is low in the following cycle.
- R5: A job with N = 0 presents no segment and raises `done` in the cycle after start.
- R6: A segment is taken only in a cycle with both `segValid` and `segReady` high. While `segReady` is low, `segValid`, `segLen`, `segSrc`, `segDst` and `segCount` hold. `segReady` while idle has no effect.
- R7: `segCount` is cleared when a job starts and increments by one per accepted segment. At `done` it equals the number of segments issued.
- R8: A start pulse while `busy` is high is ignored. The running job finishes with its original count and bases.
- R9: After reset, `busy`, `segValid` and `done` are low and `segCount` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a job; taken only while idle |
| elemCount | input | CNT_W (16) | Total element count N, sampled at start |
| srcBase | input | PTR_W (32) | Source stream base byte address, sampled at start |
| dstBase | input | PTR_W (32) | Destination stream base byte address, sampled at start |
| segValid | output | 1 | A segment is being offered |
| segReady | input | 1 | Executor takes the offered segment |
| segLen | output | VL_W (7) | Vector length of the offered segment |
| segSrc | output | PTR_W (32) | Source byte address of the segment |
| segDst | output | PTR_W (32) | Destination byte address of the segment |
| busy | output | 1 | A job is in progress |
| done | output | 1 | One-cycle strobe at job completion |
| segCount | output | CNT_W (16) | Segments accepted in the current job |

## Verification
The bound checker watches four things on every cycle:
- the bound on the offered length;
- that every segment after an accepted one is full length;
- that the handshake holds steady while stalled, and that addresses and count step correctly on each acceptance;
- that completion is followed by idle.

Only the bench's scenarios can show the rest:
- that the first length is the remainder of the job's own count;
- that the final addresses land exactly at base plus eight times N;
- that an empty or exactly divisible count behaves as specified;
- that a start pulse arriving mid-job is discarded.

// File: rtl/vl_strip_pkg.sv
package vl_strip_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seqState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;     // capture count and bases, clear segment counter
    logic advance;  // retire the offered segment
  } seqStrobe_t;

endpackage

// File: rtl/vl_strip_ctrl.sv
module vl_strip_ctrl
  import vl_strip_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       segReady,
  input  logic       remZero,
  output seqStrobe_t strobe,
  output logic       segValid,
  output logic       busy,
  output logic       done
);

  seqState_t state, nextState;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nextState;
  end

  always_comb begin
    strobe    = '0;
    nextState = state;
    case (state)
      ST_IDLE: begin
        if (start) begin
          strobe.load = 1'b1;
          nextState   = ST_RUN;
        end
      end
      ST_RUN: begin
        if (remZero)       nextState      = ST_IDLE;
        else if (segReady) strobe.advance = 1'b1;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign busy     = (state == ST_RUN);
  assign segValid = busy && !remZero;
  assign done     = busy && remZero;

endmodule

// File: rtl/vl_strip_dpath.sv
module vl_strip_dpath
  import vl_strip_pkg::*;
#(
  parameter int MAX_VL     = 64,
  parameter int ELEM_BYTES = 8,
  parameter int CNT_W      = 16,
  parameter int PTR_W      = 32,
  parameter int NUM_STR    = 2,
  localparam int LOG_VL    = $clog2(MAX_VL),
  localparam int VL_W      = LOG_VL + 1,
  localparam int LOG_EB    = $clog2(ELEM_BYTES)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  seqStrobe_t                    strobe,
  input  logic [CNT_W-1:0]              elemCount,
  input  logic [NUM_STR-1:0][PTR_W-1:0] baseVec,
  output logic                          remZero,
  output logic [VL_W-1:0]               segLen,
  output logic [NUM_STR-1:0][PTR_W-1:0] ptrVec,
  output logic [CNT_W-1:0]              segCount
);

  logic [CNT_W-1:0]  remaining;
  logic [LOG_VL-1:0] remLow;
  logic [PTR_W-1:0]  byteStep;

  // Only the first segment can be partial: after it, remaining is a multiple of MAX_VL
  assign remLow   = remaining[LOG_VL-1:0];
  assign remZero  = (remaining == '0);
  assign segLen   = (remLow == '0) ? VL_W'(MAX_VL) : {1'b0, remLow};
  assign byteStep = PTR_W'(segLen) << LOG_EB;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remaining <= '0;
      segCount  <= '0;
    end else if (strobe.load) begin
      remaining <= elemCount;
      segCount  <= '0;
    end else if (strobe.advance) begin
      remaining <= remaining - CNT_W'(segLen);
      segCount  <= segCount + 1'b1;
    end
  end

  for (genvar s = 0; s < NUM_STR; s++) begin : g_stream
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              ptrVec[s] <= '0;
      else if (strobe.load)    ptrVec[s] <= baseVec[s];
      else if (strobe.advance) ptrVec[s] <= ptrVec[s] + byteStep;
    end
  end

endmodule

// File: rtl/vl_strip_seq.sv
module vl_strip_seq
  import vl_strip_pkg::*;
#(
  parameter int MAX_VL     = 64,
  parameter int ELEM_BYTES = 8,
  parameter int CNT_W      = 16,
  parameter int PTR_W      = 32,
  localparam int VL_W      = $clog2(MAX_VL) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] elemCount,
  input  logic [PTR_W-1:0] srcBase,
  input  logic [PTR_W-1:0] dstBase,
  output logic             segValid,
  input  logic             segReady,
  output logic [VL_W-1:0]  segLen,
  output logic [PTR_W-1:0] segSrc,
  output logic [PTR_W-1:0] segDst,
  output logic             busy,
  output logic             done,
  output logic [CNT_W-1:0] segCount
);

  localparam int NUM_STR = 2;

  seqStrobe_t                    strobe;
  logic                          remZero;
  logic [NUM_STR-1:0][PTR_W-1:0] baseVec;
  logic [NUM_STR-1:0][PTR_W-1:0] ptrVec;

  assign baseVec[0] = srcBase;
  assign baseVec[1] = dstBase;
  assign segSrc     = ptrVec[0];
  assign segDst     = ptrVec[1];

  vl_strip_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .segReady (segReady),
    .remZero  (remZero),
    .strobe   (strobe),
    .segValid (segValid),
    .busy     (busy),
    .done     (done)
  );

  vl_strip_dpath #(
    .MAX_VL     (MAX_VL),
    .ELEM_BYTES (ELEM_BYTES),
    .CNT_W      (CNT_W),
    .PTR_W      (PTR_W),
    .NUM_STR    (NUM_STR)
  ) u_dpath (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .elemCount (elemCount),
    .baseVec   (baseVec),
    .remZero   (remZero),
    .segLen    (segLen),
    .ptrVec    (ptrVec),
    .segCount  (segCount)
  );

endmodule

// File: rtl/vl_strip_seq_chk.sv
module vl_strip_seq_chk #(
  parameter int MAX_VL     = 64,
  parameter int ELEM_BYTES = 8,
  parameter int CNT_W      = 16,
  parameter int PTR_W      = 32,
  localparam int VL_W      = $clog2(MAX_VL) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             segValid,
  input logic             segReady,
  input logic [VL_W-1:0]  segLen,
  input logic [PTR_W-1:0] segSrc,
  input logic [PTR_W-1:0] segDst,
  input logic             busy,
  input logic             done,
  input logic [CNT_W-1:0] segCount
);

  logic take;
  assign take = segValid && segReady;

  p_len_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    segValid |-> (segLen != '0 && segLen <= VL_W'(MAX_VL)));

  p_full_after_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (!segValid || segLen == VL_W'(MAX_VL)));

  p_src_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> segSrc == $past(segSrc) + PTR_W'($past(segLen)) * PTR_W'(ELEM_BYTES));

  p_dst_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> segDst == $past(segDst) + PTR_W'($past(segLen)) * PTR_W'(ELEM_BYTES));

  p_done_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!busy && !done));

  p_done_no_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !segValid);

  p_hold_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (segValid && !segReady) |=>
      (segValid && $stable(segLen) && $stable(segSrc) && $stable(segDst) && $stable(segCount)));

  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!segValid && !done));

  p_count_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> segCount == $past(segCount) + 1'b1);

endmodule

bind vl_strip_seq vl_strip_seq_chk #(
  .MAX_VL     (MAX_VL),
  .ELEM_BYTES (ELEM_BYTES),
  .CNT_W      (CNT_W),
  .PTR_W      (PTR_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .segValid (segValid),
  .segReady (segReady),
  .segLen   (segLen),
  .segSrc   (segSrc),
  .segDst   (segDst),
  .busy     (busy),
  .done     (done),
  .segCount (segCount)
);

// File: tb/tb_vl_strip_seq.sv
`timescale 1ns/1ps
module tb_vl_strip_seq;

  localparam int MAXV = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] elemCount = '0;
  logic [31:0] srcBase = '0;
  logic [31:0] dstBase = '0;
  logic        segReady = 1'b0;
  logic        segValid, busy, done;
  logic [6:0]  segLen;
  logic [31:0] segSrc, segDst;
  logic [15:0] segCount;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  vl_strip_seq dut (
    .clk(clk), .rst_n(rst_n), .start(start), .elemCount(elemCount),
    .srcBase(srcBase), .dstBase(dstBase), .segValid(segValid),
    .segReady(segReady), .segLen(segLen), .segSrc(segSrc), .segDst(segDst),
    .busy(busy), .done(done), .segCount(segCount)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Run one job; stall holds ready low one cycle per segment, poke fires a start mid-job
  task automatic runJob(input int n, input logic [31:0] sb, input logic [31:0] db,
                        input bit stall, input bit poke, output int segsOut);
    int expRem = n;
    longint expSrc = sb;
    longint expDst = db;
    int segs = 0;
    int guard = 0;
    int curLen;
    @(negedge clk);
    elemCount = 16'(n); srcBase = sb; dstBase = db; start = 1'b1; segReady = 1'b0;
    @(negedge clk);
    start = 1'b0;
    while (1) begin
      guard++;
      if (guard > 4000) begin
        chk(1'b0, "R4 job never completed", guard, 0);
        break;
      end
      if (done) begin
        chk(expRem == 0, "R4 done only when empty", expRem, 0);
        chk(!segValid, "R4 no segment at done", segValid, 0);
        chk(segSrc == 32'(sb + 8 * n), "R4 src end address", segSrc, 32'(sb + 8 * n));
        chk(segDst == 32'(db + 8 * n), "R4 dst end address", segDst, 32'(db + 8 * n));
        chk(segCount == 16'(segs), "R7 count at done", segCount, segs);
        @(negedge clk);
        chk(!busy && !done, "R4 idle after done", {busy, done}, 0);
        break;
      end
      chk(segValid, "R2 segment offered while elements remain", segValid, 1);
      curLen = (expRem % MAXV) != 0 ? (expRem % MAXV) : MAXV;
      chk(segLen == 7'(curLen), "R2 segment length", segLen, curLen);
      chk(segLen >= 1 && segLen <= 7'(MAXV), "R1 length bound", segLen, MAXV);
      chk(segSrc == 32'(expSrc), "R3 src address", segSrc, expSrc);
      chk(segDst == 32'(expDst), "R3 dst address", segDst, expDst);
      if (stall) begin
        segReady = 1'b0;
        if (poke && segs == 0) begin
          start = 1'b1; elemCount = 16'd5; srcBase = 32'hDEAD0000; dstBase = 32'hBEEF0000;
        end
        @(negedge clk);
        start = 1'b0;
        chk(segValid && segLen == 7'(curLen) && segSrc == 32'(expSrc)
            && segDst == 32'(expDst) && segCount == 16'(segs),
            poke ? "R8 start while busy ignored" : "R6 hold under stall",
            segCount, segs);
      end
      segReady = 1'b1;
      @(negedge clk);
      segReady = 1'b0;
      segs++;
      expRem -= curLen;
      expSrc += curLen * 8;
      expDst += curLen * 8;
      chk(segCount == 16'(segs), "R7 count step", segCount, segs);
    end
    segsOut = segs;
  endtask

  task automatic testReset();
    chk(!busy && !segValid && !done && segCount == 0, "R9 reset state",
        {busy, segValid, done}, 0);
    segReady = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(!segValid && !busy && segCount == 0, "R6 ready while idle no effect", segCount, 0);
    segReady = 1'b0;
  endtask

  task automatic testTwoHundred();
    int s;
    runJob(200, 32'h0000_1000, 32'h0008_0000, 1'b0, 1'b0, s);
    chk(s == 4, "R2 N=200 gives 8,64,64,64", s, 4);
  endtask

  task automatic testExactMultiple();
    int s;
    runJob(128, 32'h0000_0040, 32'h0000_2000, 1'b0, 1'b0, s);
    chk(s == 2, "R2 N=128 gives two full segments", s, 2);
  endtask

  task automatic testEmpty();
    int s;
    runJob(0, 32'h0000_3000, 32'h0000_4000, 1'b0, 1'b0, s);
    chk(s == 0, "R5 N=0 presents no segment", s, 0);
  endtask

  task automatic testShort();
    int s;
    runJob(1, 32'h0000_0008, 32'h0000_0010, 1'b0, 1'b0, s);
    chk(s == 1, "R2 N=1 single segment", s, 1);
    runJob(63, 32'h0001_0000, 32'h0002_0000, 1'b0, 1'b0, s);
    chk(s == 1, "R2 N=63 single segment", s, 1);
  endtask

  task automatic testStalls();
    int s;
    runJob(65, 32'h0003_0000, 32'h0004_0000, 1'b1, 1'b0, s);
    chk(s == 2, "R6 N=65 under stalls", s, 2);
  endtask

  task automatic testRestartIgnored();
    int s;
    runJob(200, 32'h0005_0000, 32'h0006_0000, 1'b1, 1'b1, s);
    chk(s == 4, "R8 job kept original count", s, 4);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    testTwoHundred();
    testExactMultiple();
    testEmpty();
    testShort();
    testStalls();
    testRestartIgnored();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule